// File: doc/BRIEF.md
# Clear-on-read frame loss statistics register

This block keeps count of lost receive frames for the receive path of a network DMA engine. Two independent causes of loss are tracked. The first is a frame dropped because no host receive buffer was free. The second is an overflow of the receive FIFO. Each cause has its own wrapping counter and a sticky flag that records when that counter rolled over. Both counters and both flags are packed into a single 32-bit status word.

Software reads the word through a simple read strobe. The read returns the current value in the same cycle and clears the whole word at the following clock edge. An event that coincides with a read is not lost: it is counted into the freshly cleared counter. The word cannot be written. The default widths are a 16-bit buffer-miss counter and an 11-bit FIFO-overflow counter.

Top module: `frameLossStats`

## Requirements
- R1: Each clock cycle with `missPulse` high (and no read) adds one to the buffer-miss counter, which appears at `rdData[15:0]`.
- R2: A `missPulse` while the buffer-miss counter holds 0xFFFF wraps it to zero and sets the miss rollover flag at `rdData[16]`.
- R3: Each clock cycle with `ovfPulse` high (and no read) adds one to the FIFO-overflow counter, which appears at `rdData[27:17]`.
- R4: An `ovfPulse` while the FIFO-overflow counter holds 0x7FF wraps it to zero and sets the overflow rollover flag at `rdData[28]`.
- R5: A cycle with `rdEn` high presents the current word on `rdData`, and after that clock edge both counters and both rollover flags read as zero.
- R6: After reset, `rdData` is zero.
- R7: A rollover flag remains set while its counter keeps advancing, until a read clears it.
- R8: When an event pulse and `rdEn` are high in the same cycle, the read returns the value from before the event, and the affected counter reads 1 afterwards.
- R9: `rdData[31:29]` is always zero.
- R10: The two pulses may be high in the same cycle, and each counter then advances by one. A pulse on one input leaves the other counter unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| rdEn | input | 1 | Read strobe; clears the word at the next edge |
| missPulse | input | 1 | One frame dropped because no host buffer was free |
| ovfPulse | input | 1 | One receive FIFO overflow |
| rdData | output | 32 | Packed status word |

## Verification
The hardest state to reach from the ports is a 16-bit counter rollover. That rollover needs 65,536 counted events with no read in between. The bench drives `missPulse` high on every cycle of a long run until the counter holds 0xFFFF. It checks that the flag is still clear at that point, then gives one more pulse to cause the wrap. It then keeps pulsing so that the flag can be seen to stay set while the counter moves. The 11-bit counter wrap is reached the same way in a shorter run.

// File: rtl/frameLossStatsPkg.sv
package frameLossStatsPkg;

  // Strobes from the control side to the counting datapath.
  typedef struct packed {
    logic clrAll;    // read in progress: clear everything at this edge
    logic bumpMiss;  // buffer-miss event this cycle
    logic bumpOvf;   // FIFO-overflow event this cycle
  } lossStrobes_t;

endpackage

// File: rtl/lossCountLane.sv
module lossCountLane #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic         bump,
  output logic [W-1:0] count,
  output logic         wrapped
);

  localparam logic [W-1:0] MAX_VAL = '1;
  localparam logic [W-1:0] ONE_VAL = {{(W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      wrapped <= 1'b0;
    end else if (clr) begin
      count   <= bump ? ONE_VAL : '0;
      wrapped <= 1'b0;
    end else if (bump) begin
      count <= count + ONE_VAL;
      if (count == MAX_VAL) wrapped <= 1'b1;
    end
  end

  // R1/R3: a single event below the maximum advances the count by one
  a_r1_r3_step: assert property (@(posedge clk) disable iff (!rstN)
    (bump && !clr && count != MAX_VAL) |=> (count == $past(count) + ONE_VAL));

  // R2/R4: an event at the maximum wraps to zero and raises the flag
  a_r2_r4_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (bump && !clr && count == MAX_VAL) |=> (count == '0 && wrapped));

  // R5: a read with no event leaves the lane empty
  a_r5_clear: assert property (@(posedge clk) disable iff (!rstN)
    (clr && !bump) |=> (count == '0 && !wrapped));

  // R7: the flag holds until a read
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (wrapped && !clr) |=> wrapped);

  // R8: a coinciding event restarts the count at one
  a_r8_keep_event: assert property (@(posedge clk) disable iff (!rstN)
    (clr && bump) |=> (count == ONE_VAL && !wrapped));

endmodule

// File: rtl/lossStatsCtrl.sv
module lossStatsCtrl
  import frameLossStatsPkg::*;
(
  input  logic         rdEn,
  input  logic         missPulse,
  input  logic         ovfPulse,
  output lossStrobes_t strobes
);

  always_comb begin
    strobes          = '0;
    strobes.clrAll   = rdEn;
    strobes.bumpMiss = missPulse;
    strobes.bumpOvf  = ovfPulse;
  end

endmodule

// File: rtl/lossStatsDatapath.sv
module lossStatsDatapath
  import frameLossStatsPkg::*;
#(
  parameter int MISS_W = 16,
  parameter int OVF_W  = 11,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  lossStrobes_t      strobes,
  output logic [WORD_W-1:0] statusWord
);

  localparam int USED_W = MISS_W + OVF_W + 2;
  localparam int PAD_W  = WORD_W - USED_W;

  logic [MISS_W-1:0] missCount;
  logic              missWrap;
  logic [OVF_W-1:0]  ovfCount;
  logic              ovfWrap;

  lossCountLane #(.W(MISS_W)) missLane (
    .clk     (clk),
    .rstN    (rstN),
    .clr     (strobes.clrAll),
    .bump    (strobes.bumpMiss),
    .count   (missCount),
    .wrapped (missWrap)
  );

  lossCountLane #(.W(OVF_W)) ovfLane (
    .clk     (clk),
    .rstN    (rstN),
    .clr     (strobes.clrAll),
    .bump    (strobes.bumpOvf),
    .count   (ovfCount),
    .wrapped (ovfWrap)
  );

  generate
    if (PAD_W > 0) begin : gPad
      assign statusWord = {{PAD_W{1'b0}}, ovfWrap, ovfCount, missWrap, missCount};
    end else begin : gNoPad
      assign statusWord = {ovfWrap, ovfCount, missWrap, missCount};
    end
  endgenerate

  // R10: an event on one lane leaves the other lane untouched
  a_r10_miss_only: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.bumpMiss && !strobes.bumpOvf && !strobes.clrAll)
      |=> ($stable(ovfCount) && $stable(ovfWrap)));

  a_r10_ovf_only: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.bumpOvf && !strobes.bumpMiss && !strobes.clrAll)
      |=> ($stable(missCount) && $stable(missWrap)));

endmodule

// File: rtl/frameLossStats.sv
module frameLossStats
  import frameLossStatsPkg::*;
#(
  parameter int MISS_W = 16,
  parameter int OVF_W  = 11,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic              missPulse,
  input  logic              ovfPulse,
  output logic [WORD_W-1:0] rdData
);

  lossStrobes_t strobes;

  lossStatsCtrl ctrl (
    .rdEn      (rdEn),
    .missPulse (missPulse),
    .ovfPulse  (ovfPulse),
    .strobes   (strobes)
  );

  lossStatsDatapath #(
    .MISS_W (MISS_W),
    .OVF_W  (OVF_W),
    .WORD_W (WORD_W)
  ) dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .statusWord (rdData)
  );

  // R5: a read with no events leaves an all-zero word
  a_r5_word_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !missPulse && !ovfPulse) |=> (rdData == '0));

endmodule

// File: tb/frameLossStats_test.sv
module frameLossStats_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdEn = 1'b0;
  logic        missPulse = 1'b0;
  logic        ovfPulse = 1'b0;
  logic [31:0] rdData;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  frameLossStats uut (
    .clk       (clk),
    .rstN      (rstN),
    .rdEn      (rdEn),
    .missPulse (missPulse),
    .ovfPulse  (ovfPulse),
    .rdData    (rdData)
  );

  function automatic logic [31:0] packWord(int m, bit mf, int o, bit of);
    logic [15:0] mv = m[15:0];
    logic [10:0] ov = o[10:0];
    return {3'b000, of, ov, mf, mv};
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Drive both pulses for n cycles; sampling stays on negedges.
  task automatic pulse(bit m, bit o, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      missPulse = m;
      ovfPulse  = o;
    end
    @(negedge clk);
    missPulse = 1'b0;
    ovfPulse  = 1'b0;
  endtask

  // Read cycle: check the presented word, then check it is cleared.
  task automatic readAndClear(string req, logic [31:0] exp);
    @(negedge clk);
    rdEn = 1'b1;
    #1;
    check(req, rdData, exp);
    check("R9", {29'd0, rdData[31:29]}, 32'd0);
    @(negedge clk);
    rdEn = 1'b0;
    #1;
    check("R5", rdData, 32'd0);
  endtask

  task automatic testReset();
    #1;
    check("R6", rdData, 32'd0);
  endtask

  task automatic testSeparate();
    pulse(1, 0, 5);
    #1;
    check("R10", rdData, packWord(5, 0, 0, 0));
    pulse(0, 1, 3);
    #1;
    check("R10", rdData, packWord(5, 0, 3, 0));
    readAndClear("R1 R3", packWord(5, 0, 3, 0));
  endtask

  task automatic testTogether();
    pulse(1, 1, 7);
    readAndClear("R10", packWord(7, 0, 7, 0));
  endtask

  task automatic testMissWrap();
    pulse(1, 0, 65535);
    #1;
    check("R1", rdData, packWord(65535, 0, 0, 0));
    pulse(1, 0, 1);
    #1;
    check("R2", rdData, packWord(0, 1, 0, 0));
    pulse(1, 0, 3);
    #1;
    check("R7", rdData, packWord(3, 1, 0, 0));
    readAndClear("R5", packWord(3, 1, 0, 0));
  endtask

  task automatic testOvfWrap();
    pulse(0, 1, 2047);
    #1;
    check("R3", rdData, packWord(0, 0, 2047, 0));
    pulse(0, 1, 1);
    #1;
    check("R4", rdData, packWord(0, 0, 0, 1));
    pulse(1, 1, 2);
    #1;
    check("R7", rdData, packWord(2, 0, 2, 1));
    readAndClear("R5", packWord(2, 0, 2, 1));
  endtask

  task automatic testReadCollision();
    pulse(1, 1, 4);
    @(negedge clk);
    rdEn = 1'b1;
    missPulse = 1'b1;
    ovfPulse = 1'b1;
    #1;
    check("R8", rdData, packWord(4, 0, 4, 0));
    @(negedge clk);
    rdEn = 1'b0;
    missPulse = 1'b0;
    ovfPulse = 1'b0;
    #1;
    check("R8", rdData, packWord(1, 0, 1, 0));
    readAndClear("R8", packWord(1, 0, 1, 0));
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    join_none
    #12;
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R6", rdData, 32'd0);
    testSeparate();
    testTogether();
    testMissWrap();
    testOvfWrap();
    testReadCollision();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule